// File: doc/BRIEF.md
# ADC Sample-Stream DC-Blocking High-Pass Filter

This block sits right after a 10-bit analog-to-digital converter. Each clock it can take one two's complement sample, marked by a valid strobe. It runs the samples through a first-order recursive high-pass filter, which removes the DC offset and drift well below the sample rate. The filter's zero is just inside unity and its pole sits a little further in, which places the −3 dB corner near one four-hundredth of the sample rate. The filter adds exactly one clock of latency.

A bypass control routes samples straight to the output in the same cycle, with no added latency. While bypass is set, the filter state keeps tracking the input, so turning bypass off resumes filtering without a restart transient from cleared state. A format control flips only the most significant bit of the presented word, which turns two's complement into straight (offset) binary.

The stream has a valid strobe and no ready. A converter cannot be paused, so the block accepts every sample its input marks valid, and the consumer must take every output word the cycle it is marked valid. No back-pressure exists in either direction.

Top module: `adc_hpf_stream`

## Requirements
- R1: Input and output words are two's complement (0x1FF largest, 0x000 zero, 0x3FF minus one, 0x200 most negative). With `unsigned_out` high, the presented word has bit 9 inverted and bits 8..0 unchanged. With it low, the word is passed as is.
- R2: The filter keeps x_prev (10-bit signed) and y_state (signed, 16 fractional bits). For each accepted filtered sample it forms acc = x·2^16 − 65532·x_prev + floor(64531·y_state / 2^16), then sets y_state = acc and x_prev = x.
- R3: The filtered output word is acc rounded half-up to an integer, floor((acc + 2^15) / 2^16), and then saturated to the range −512..+511 rather than wrapped.
- R4: With bypass low, a sample accepted in cycle n appears on `out_sample` with `out_valid` high in cycle n+1.
- R5: With bypass high, a valid input sample appears on the output in the same cycle with `out_valid` high and its value unchanged, apart from the R1 format flip.
- R6: Filter state and outputs advance only on cycles with `in_valid` high. Idle cycles between samples do not change the filtered result.
- R7: Samples accepted while bypass is high still update x_prev and y_state. Changing bypass clears no state.
- R8: If a filtered result is due in the same cycle as a bypassed valid sample, the bypassed sample is presented and the filtered result is discarded.
- R9: A synchronous active-high reset clears x_prev and y_state to zero and drops `out_valid`. The first filtered output after reset equals its input sample.
- R10: A constant input held for 1500 samples settles to an output within ±2 of zero. A positive step from zero gives a first output equal to the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one converter sample per cycle at most |
| rst | input | 1 | Synchronous active-high reset |
| in_sample | input | 10 | Two's complement converter sample |
| in_valid | input | 1 | High when `in_sample` carries a sample |
| bypass | input | 1 | High: pass samples through unfiltered with zero latency |
| unsigned_out | input | 1 | High: present straight binary (MSB inverted) |
| out_sample | output | 10 | Filtered or bypassed sample word |
| out_valid | output | 1 | High when `out_sample` carries a word |

## Verification
The bench targets the full-scale steps from −512 to +511 and back. A design that wraps instead of saturating would show the opposite sign at the rail. It also targets the first sample after reset, where stale x_prev would pull the output away from the input value. Mode changes from filter to bypass in consecutive cycles are driven so that a design that drops the wrong word, or stalls the state during bypass, diverges from the bit-accurate model. Long constant runs expose a feedback path that truncates y_state to the integer grid: that design settles on a dead-band value instead of decaying.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

  // Quantize a coefficient in [0,1) to an unsigned fixed-point integer with
  // frac_bits fractional bits, rounding to nearest.
  function automatic int quantize_coef(input real value, input int frac_bits);
    real scaled;
    scaled = value * (2.0 ** frac_bits);
    return $rtoi(scaled + 0.5);
  endfunction

  // Output word presentation.
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } out_fmt_e;

endpackage

// File: rtl/hpf_recursion.sv
// First-order recursion: acc = x*2^F - B*x_prev + floor(A*y_state/2^F).
// State advances only when 'advance' is high.
module hpf_recursion #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 16,
  parameter int COEF_A = 64531,
  parameter int COEF_B = 65532,
  localparam int Y_W   = DATA_W + 2 + FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [Y_W-1:0]    acc_o
);

  localparam int PB_W  = DATA_W + FRAC_W + 1;
  localparam int PA_W  = Y_W + FRAC_W + 1;
  localparam int SUM_W = Y_W + 2;

  localparam logic signed [FRAC_W:0] A_S = COEF_A[FRAC_W:0];
  localparam logic signed [FRAC_W:0] B_S = COEF_B[FRAC_W:0];

  logic signed [DATA_W-1:0] x_prev_q;
  logic signed [Y_W-1:0]    y_state_q;

  logic signed [PB_W-1:0]   prod_b;
  logic signed [PA_W-1:0]   prod_a;
  logic signed [SUM_W-1:0]  x_scaled;
  logic signed [SUM_W-1:0]  fwd_term;
  logic signed [SUM_W-1:0]  fb_term;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    prod_b   = B_S * x_prev_q;
    prod_a   = A_S * y_state_q;
    x_scaled = {{(SUM_W-DATA_W-FRAC_W){x_in[DATA_W-1]}}, x_in, {FRAC_W{1'b0}}};
    fwd_term = SUM_W'(prod_b);
    fb_term  = SUM_W'(prod_a >>> FRAC_W);
    sum      = x_scaled - fwd_term + fb_term;
    acc_o    = Y_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev_q  <= '0;
      y_state_q <= '0;
    end else if (advance) begin
      x_prev_q  <= x_in;
      y_state_q <= acc_o;
    end
  end

endmodule

// File: rtl/hpf_round_sat.sv
// Round half-up from the fixed-point accumulator to an integer and clamp
// to the two's complement range of the output word.
module hpf_round_sat #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 16,
  localparam int Y_W   = DATA_W + 2 + FRAC_W
) (
  input  logic signed [Y_W-1:0]    acc_i,
  output logic signed [DATA_W-1:0] y_o
);

  localparam int R_W  = Y_W + 1;
  localparam int IW   = R_W - FRAC_W;
  localparam logic signed [R_W-1:0]    HALF  = R_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [IW-1:0]     MAX_I = IW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [IW-1:0]     MIN_I = -IW'(1 << (DATA_W - 1));
  localparam logic signed [DATA_W-1:0] MAX_D = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_D = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [R_W-1:0] rounded;
  logic signed [IW-1:0]  int_part;

  always_comb begin
    rounded  = R_W'(acc_i) + HALF;
    int_part = IW'(rounded >>> FRAC_W);
    if (int_part > MAX_I)      y_o = MAX_D;
    else if (int_part < MIN_I) y_o = MIN_D;
    else                       y_o = DATA_W'(int_part);
  end

endmodule

// File: rtl/hpf_out_stage.sv
// Registers the filtered word (one cycle latency), muxes the zero-latency
// bypass path ahead of it and applies the output format.
module hpf_out_stage
  import hpf_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              bypass,
  input  logic [DATA_W-1:0] raw_word,
  input  logic [DATA_W-1:0] filt_word,
  input  out_fmt_e          fmt,
  output logic [DATA_W-1:0] out_word,
  output logic              out_valid
);

  logic [DATA_W-1:0] filt_q;
  logic              filt_vld_q;
  logic              pass_now;
  logic [DATA_W-1:0] chosen;
  logic [DATA_W-1:0] flip_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_vld_q <= 1'b0;
      filt_q     <= '0;
    end else begin
      filt_vld_q <= in_valid & ~bypass;
      if (in_valid & ~bypass) filt_q <= filt_word;
    end
  end

  always_comb begin
    pass_now  = in_valid & bypass;
    chosen    = pass_now ? raw_word : filt_q;
    flip_mask = {(fmt == FMT_OFFSET), {(DATA_W-1){1'b0}}};
    out_word  = chosen ^ flip_mask;
    out_valid = pass_now | filt_vld_q;
  end

endmodule

// File: rtl/adc_hpf_stream.sv
module adc_hpf_stream
  import hpf_pkg::*;
#(
  parameter int  DATA_W = 10,
  parameter int  FRAC_W = 16,
  parameter real POLE   = 0.98466,
  parameter real ZERO   = 0.99994
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              in_valid,
  input  logic              bypass,
  input  logic              unsigned_out,
  output logic [DATA_W-1:0] out_sample,
  output logic              out_valid
);

  localparam int COEF_A = quantize_coef(POLE, FRAC_W);
  localparam int COEF_B = quantize_coef(ZERO, FRAC_W);
  localparam int Y_W    = DATA_W + 2 + FRAC_W;

  logic signed [Y_W-1:0]    acc;
  logic signed [DATA_W-1:0] filt_word;
  out_fmt_e                 fmt;

  assign fmt = out_fmt_e'(unsigned_out);

  hpf_recursion #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .COEF_A (COEF_A),
    .COEF_B (COEF_B)
  ) rec_i (
    .clk     (clk),
    .rst     (rst),
    .advance (in_valid),
    .x_in    ($signed(in_sample)),
    .acc_o   (acc)
  );

  hpf_round_sat #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
  ) rsat_i (
    .acc_i (acc),
    .y_o   (filt_word)
  );

  hpf_out_stage #(
    .DATA_W (DATA_W)
  ) ostg_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .raw_word  (in_sample),
    .filt_word (filt_word),
    .fmt       (fmt),
    .out_word  (out_sample),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/hpf_stream_checker.sv
module hpf_stream_checker #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] in_sample,
  input logic              in_valid,
  input logic              bypass,
  input logic              unsigned_out,
  input logic [DATA_W-1:0] out_sample,
  input logic              out_valid
);

  // R4
  filt_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !bypass) |=> out_valid);

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) |-> (out_valid &&
      out_sample[DATA_W-2:0] == in_sample[DATA_W-2:0] &&
      out_sample[DATA_W-1] == (in_sample[DATA_W-1] ^ unsigned_out)));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !(in_valid && bypass)) |-> !out_valid);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(in_valid && bypass)) |-> $past(in_valid && !bypass));

endmodule

bind adc_hpf_stream hpf_stream_checker #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_sample    (in_sample),
  .in_valid     (in_valid),
  .bypass       (bypass),
  .unsigned_out (unsigned_out),
  .out_sample   (out_sample),
  .out_valid    (out_valid)
);

// File: tb/adc_hpf_stream_tb_top.sv
module adc_hpf_stream_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_sample = '0;
  logic         in_valid = 1'b0;
  logic         bypass = 1'b0;
  logic         unsigned_out = 1'b0;
  logic [W-1:0] out_sample;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  longint m_xp = 0;
  longint m_ys = 0;
  bit     pend_v = 1'b0;
  int     pend_y = 0;
  int     obs_v;
  int     obs_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_hpf_stream dut_i (
    .clk          (clk),
    .rst          (rst),
    .in_sample    (in_sample),
    .in_valid     (in_valid),
    .bypass       (bypass),
    .unsigned_out (unsigned_out),
    .out_sample   (out_sample),
    .out_valid    (out_valid)
  );

  function automatic int model_step(input int x);
    longint acc;
    longint r;
    acc = (longint'(x) <<< 16) - 64'sd65532 * m_xp + ((64'sd64531 * m_ys) >>> 16);
    m_xp = x;
    m_ys = acc;
    r = (acc + 64'sd32768) >>> 16;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return int'(r);
  endfunction

  function automatic int as_signed(input logic [W-1:0] w);
    return int'($signed(w));
  endfunction

  function automatic logic [W-1:0] present(input int v, input logic fmt);
    logic [W-1:0] w;
    w = W'(v);
    w[W-1] = w[W-1] ^ fmt;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, sample a quarter period later (before posedge).
  task automatic do_cycle(input logic v, input int x, input logic byp, input logic fmt,
                          input string tag);
    logic         exp_v;
    logic [W-1:0] exp_w;
    string        rq;
    @(negedge clk);
    in_valid     = v;
    in_sample    = W'(x);
    bypass       = byp;
    unsigned_out = fmt;
    #(CLK_PERIOD/4);
    if (v && byp) begin
      exp_v = 1'b1; exp_w = present(x, fmt);
      rq = pend_v ? {tag, " R8 R5"} : {tag, " R5"};
    end else if (pend_v) begin
      exp_v = 1'b1; exp_w = present(pend_y, fmt);
      rq = (pend_y == 511 || pend_y == -512) ? {tag, " R4 R2 R3"} : {tag, " R4 R2"};
    end else begin
      exp_v = 1'b0; exp_w = '0;
      rq = {tag, " R6"};
    end
    if (fmt) rq = {rq, " R1"};
    obs_v = int'(out_valid);
    obs_y = as_signed(out_sample);
    check(out_valid === exp_v, {rq, " valid"}, int'(out_valid), int'(exp_v));
    if (exp_v) check(out_sample === exp_w, rq, int'(out_sample), int'(exp_w));
    pend_v = v && !byp;
    if (v) pend_y = model_step(x);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; bypass = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_xp = 0; m_ys = 0; pend_v = 1'b0;
    #(CLK_PERIOD/4);
    // R9: no output straight after reset
    check(out_valid === 1'b0, "R9 valid after reset", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    apply_reset();

    // R9: first output after reset equals its input (state cleared)
    do_cycle(1'b1, 300, 1'b0, 1'b0, "R9");
    do_cycle(1'b0, 0, 1'b0, 1'b0, "R9");
    check(obs_v == 1 && obs_y == 300, "R9 R10 first output equals step", obs_y, 300);

    // R10: constant input decays toward zero
    for (int i = 0; i < 1500; i++) do_cycle(1'b1, 300, 1'b0, 1'b0, "R10");
    do_cycle(1'b0, 0, 1'b0, 1'b0, "R10");
    check(obs_y <= 2 && obs_y >= -2, "R10 settled near zero", obs_y, 0);

    // R3: full-scale steps saturate with the correct sign
    for (int i = 0; i < 1500; i++) do_cycle(1'b1, -512, 1'b0, 1'b0, "R3");
    do_cycle(1'b1, 511, 1'b0, 1'b0, "R3");
    do_cycle(1'b1, 511, 1'b0, 1'b0, "R3");
    check(obs_y == 511, "R3 positive step saturates", obs_y, 511);
    for (int i = 0; i < 1500; i++) do_cycle(1'b1, 511, 1'b0, 1'b0, "R3");
    do_cycle(1'b1, -512, 1'b0, 1'b0, "R3");
    do_cycle(1'b0, 0, 1'b0, 1'b0, "R3");
    check(obs_y == -512, "R3 negative step saturates", obs_y, -512);

    // R1: format flip on bypassed words
    do_cycle(1'b1, 0, 1'b1, 1'b1, "R1");
    check(out_sample === 10'h200, "R1 zero as offset binary", int'(out_sample), 'h200);
    do_cycle(1'b1, -1, 1'b1, 1'b1, "R1");
    check(out_sample === 10'h1FF, "R1 minus one as offset binary", int'(out_sample), 'h1FF);

    // R8: filtered then bypassed in consecutive cycles
    do_cycle(1'b1, 100, 1'b0, 1'b0, "R8");
    do_cycle(1'b1, -77, 1'b1, 1'b0, "R8");
    check(obs_y == -77, "R8 bypassed word wins", obs_y, -77);
    do_cycle(1'b0, 0, 1'b0, 1'b0, "R8");
    check(obs_v == 0, "R8 dropped filtered word stays dropped", obs_v, 0);

    // R6: sparse valid with idle gaps
    for (int i = 0; i < 1500; i++)
      do_cycle(($urandom % 3) == 0, int'($urandom % 1024) - 512, 1'b0, 1'b0, "R6");

    // R7: bypass toggling with state continuing underneath
    for (int i = 0; i < 2000; i++)
      do_cycle(($urandom % 4) != 0, int'($urandom % 1024) - 512,
               ($urandom % 8) < 3, 1'b0, "R7");

    // Mixed random with format changes, mid-run reset
    apply_reset();
    for (int i = 0; i < 3000; i++)
      do_cycle(($urandom % 5) != 0, int'($urandom % 1024) - 512,
               ($urandom % 16) == 0, 1'(($urandom % 2)), "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule